// File: doc/BRIEF.md
# Virtqueue Descriptor Chain Walker

This block takes the next buffer a guest has offered on a split virtqueue and turns it into a list of memory segments. On a fetch command it reads the guest's published index from the available ring, compares it with its own consumer index, reads the head descriptor number from the ring, and then walks the linked descriptor table. Each descriptor is streamed out as one segment with its address, its length and a tag that says whether the device writes it (in) or reads it (out). A completion pulse reports the head number as the element identifier, along with the counts of in and out segments.

All guest memory is reached through a single read port with a valid/ready request and a response valid, and only one request is outstanding at a time. The ring base addresses and the queue size come from a configuration block. A remove control sets whether a fetch consumes the element. A skip command consumes an element without walking it. A chain that loops back on itself is cut off after a parameterised number of segments, and a sticky error flag is raised.

Top module: `vq_chain_walker`

## Requirements
- R1: A fetch or skip first reads the 16-bit published index at avail_base_i+2. If it equals the 16-bit consumer index, the command completes with done_empty_o=1, no segments and no further reads, and the consumer index is unchanged.
- R2: A non-empty fetch reads the head number at avail_base_i+4+2*(consumer & (qsize_i-1)) and reports it, unmasked, on done_id_o. qsize_i is a power of two.
- R3: Descriptor n is read as two 8-byte words. The word at desc_base_i+16*(n & (qsize_i-1)) is the segment address. The word 8 bytes above it holds the length in bits 31:0, the flags in bits 47:32 and the next index in bits 63:48. A read response carries the aligned 8-byte word, and a 16-bit field is taken from lane addr[2:1].
- R4: Each descriptor produces one seg_valid_o pulse carrying its address and length. seg_in_o equals flag bit 1 (write), and the segment is counted as in when that bit is set and as out when it is clear.
- R5: The walk continues to the descriptor named by the next field while flag bit 0 (next) is set. It ends at the first descriptor that has the bit clear, and the completion reports the in and out counts.
- R6: A non-empty fetch with remove_i=1 advances the consumer index by one, modulo 2^16. With remove_i=0 the index is left unchanged.
- R7: A skip on a non-empty queue advances the consumer index by one without reading any descriptor. On an empty queue it changes nothing.
- R8: When a descriptor with the next flag set would be followed after MAX_SEGS segments have been emitted, the walk stops, and loop_err_o is set and stays set until reset. A chain of exactly MAX_SEGS descriptors whose last one has the next flag clear raises no error.
- R9: Only one memory read is outstanding at a time. A request holds its valid and its address stable until it is accepted.
- R10: After reset the block is idle: no request, no pulse, loop_err_o=0 and a consumer index of 0.
- R11: When fetch_i and skip_i are asserted in the same cycle, the fetch wins. Commands that arrive while busy_o=1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_base_i | input | AW | Descriptor table byte address |
| avail_base_i | input | AW | Available ring byte address |
| qsize_i | input | 16 | Queue size, a power of two |
| fetch_i | input | 1 | Fetch the next element |
| skip_i | input | 1 | Consume the next element without walking it |
| remove_i | input | 1 | Fetch advances the consumer index |
| busy_o | output | 1 | Command in progress |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_addr_o | output | AW | Read byte address |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Aligned 8-byte read data |
| seg_valid_o | output | 1 | Segment pulse |
| seg_addr_o | output | 64 | Segment address |
| seg_len_o | output | 32 | Segment length |
| seg_in_o | output | 1 | Segment is device-writable |
| done_o | output | 1 | Command complete pulse |
| done_empty_o | output | 1 | Queue was empty |
| done_id_o | output | 16 | Head descriptor number |
| done_in_cnt_o | output | CW | In segment count |
| done_out_cnt_o | output | CW | Out segment count |
| loop_err_o | output | 1 | Sticky looped-chain flag |

## Verification
The bench builds the block with MAX_SEGS=8 and drives a queue size of 8. With these values a self-referencing descriptor hits the abort limit after eight segments, and a chain that fills the whole table lands exactly on that limit without tripping it. Because the queue size is small, head numbers above the size test the index masking. The memory model stalls ready in a repeating pattern, so that requests are held across several cycles.

// File: rtl/vqw_pkg.sv
package vqw_pkg;
  localparam int IDX_W = 16;
  localparam int FLG_NEXT = 32;  // bit of the high descriptor word
  localparam int FLG_WRITE = 33;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} state_e;
  typedef enum logic [1:0] {PH_AIDX, PH_HEAD, PH_DLO, PH_DHI} phase_e;

  function automatic logic [IDX_W-1:0] lane16(input logic [63:0] d, input logic [1:0] sel);
    return d[sel*16 +: 16];
  endfunction
endpackage

// File: rtl/vqw_addr_gen.sv
module vqw_addr_gen #(
  parameter int AW = 64
) (
  input  vqw_pkg::phase_e              ph_i,
  input  logic [AW-1:0]                desc_base_i,
  input  logic [AW-1:0]                avail_base_i,
  input  logic [vqw_pkg::IDX_W-1:0]    qmask_i,
  input  logic [vqw_pkg::IDX_W-1:0]    nxt_i,
  input  logic [vqw_pkg::IDX_W-1:0]    cur_i,
  output logic [AW-1:0]                addr_o
);
  import vqw_pkg::*;
  logic [AW-1:0] ring_off, desc_off;

  assign ring_off = AW'(nxt_i & qmask_i) << 1;
  assign desc_off = AW'(cur_i & qmask_i) << 4;

  always_comb begin
    case (ph_i)
      PH_AIDX: addr_o = avail_base_i + AW'(2);
      PH_HEAD: addr_o = avail_base_i + AW'(4) + ring_off;
      PH_DLO:  addr_o = desc_base_i + desc_off;
      default: addr_o = desc_base_i + desc_off + AW'(8);
    endcase
  end
endmodule

// File: rtl/vqw_seg_count.sv
module vqw_seg_count #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic          is_in_i,
  output logic [CW-1:0] in_cnt_o,
  output logic [CW-1:0] out_cnt_o,
  output logic [CW-1:0] total_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt_o  <= '0;
      out_cnt_o <= '0;
    end else if (clr_i) begin
      in_cnt_o  <= '0;
      out_cnt_o <= '0;
    end else if (inc_i) begin
      if (is_in_i) in_cnt_o <= in_cnt_o + CW'(1);
      else         out_cnt_o <= out_cnt_o + CW'(1);
    end
  end

  assign total_o = in_cnt_o + out_cnt_o;
endmodule

// File: rtl/vq_chain_walker.sv
module vq_chain_walker #(
  parameter int AW = 64,
  parameter int MAX_SEGS = 1024,
  localparam int CW = $clog2(MAX_SEGS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] desc_base_i,
  input  logic [AW-1:0] avail_base_i,
  input  logic [15:0]   qsize_i,
  input  logic          fetch_i,
  input  logic          skip_i,
  input  logic          remove_i,
  output logic          busy_o,
  output logic          mem_req_valid_o,
  output logic [AW-1:0] mem_req_addr_o,
  input  logic          mem_req_ready_i,
  input  logic          mem_rsp_valid_i,
  input  logic [63:0]   mem_rsp_data_i,
  output logic          seg_valid_o,
  output logic [63:0]   seg_addr_o,
  output logic [31:0]   seg_len_o,
  output logic          seg_in_o,
  output logic          done_o,
  output logic          done_empty_o,
  output logic [15:0]   done_id_o,
  output logic [CW-1:0] done_in_cnt_o,
  output logic [CW-1:0] done_out_cnt_o,
  output logic          loop_err_o
);
  import vqw_pkg::*;

  localparam logic [CW-1:0] LIMIT = CW'(MAX_SEGS - 1);

  state_e st_q;
  phase_e ph_q;
  logic [IDX_W-1:0] nxt_q, cur_q, head_q;
  logic is_skip_q, rm_q, empty_q, loop_q;
  logic [63:0] saddr_q, seg_addr_q;
  logic [31:0] seg_len_q;
  logic seg_v_q, seg_in_q;
  logic [IDX_W-1:0] rsp16;
  logic accept, rsp_hi;
  logic [CW-1:0] total;

  assign accept = (st_q == S_IDLE) && (fetch_i || skip_i);
  assign rsp_hi = (st_q == S_WAIT) && (ph_q == PH_DHI) && mem_rsp_valid_i;
  assign rsp16  = lane16(mem_rsp_data_i, mem_req_addr_o[2:1]);

  vqw_addr_gen #(.AW(AW)) i_addr (
    .ph_i(ph_q), .desc_base_i(desc_base_i), .avail_base_i(avail_base_i),
    .qmask_i(qsize_i - 16'd1), .nxt_i(nxt_q), .cur_i(cur_q), .addr_o(mem_req_addr_o)
  );

  vqw_seg_count #(.CW(CW)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .inc_i(rsp_hi),
    .is_in_i(mem_rsp_data_i[FLG_WRITE]),
    .in_cnt_o(done_in_cnt_o), .out_cnt_o(done_out_cnt_o), .total_o(total)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;  ph_q <= PH_AIDX;
      nxt_q <= '0;  cur_q <= '0;  head_q <= '0;
      is_skip_q <= 1'b0;  rm_q <= 1'b0;  empty_q <= 1'b0;  loop_q <= 1'b0;
      saddr_q <= '0;  seg_addr_q <= '0;  seg_len_q <= '0;
      seg_v_q <= 1'b0;  seg_in_q <= 1'b0;
    end else begin
      seg_v_q <= 1'b0;
      case (st_q)
        S_IDLE: if (accept) begin
          is_skip_q <= !fetch_i;  // fetch wins
          rm_q      <= remove_i;
          empty_q   <= 1'b0;
          ph_q      <= PH_AIDX;
          st_q      <= S_REQ;
        end
        S_REQ: if (mem_req_ready_i) st_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid_i) begin
          case (ph_q)
            PH_AIDX: begin
              if (rsp16 == nxt_q) begin
                empty_q <= 1'b1;
                st_q    <= S_DONE;
              end else if (is_skip_q) begin
                nxt_q <= nxt_q + 16'd1;
                st_q  <= S_DONE;
              end else begin
                ph_q <= PH_HEAD;
                st_q <= S_REQ;
              end
            end
            PH_HEAD: begin
              head_q <= rsp16;
              cur_q  <= rsp16;
              if (rm_q) nxt_q <= nxt_q + 16'd1;
              ph_q <= PH_DLO;
              st_q <= S_REQ;
            end
            PH_DLO: begin
              saddr_q <= mem_rsp_data_i;
              ph_q    <= PH_DHI;
              st_q    <= S_REQ;
            end
            default: begin
              seg_v_q    <= 1'b1;
              seg_addr_q <= saddr_q;
              seg_len_q  <= mem_rsp_data_i[31:0];
              seg_in_q   <= mem_rsp_data_i[FLG_WRITE];
              if (mem_rsp_data_i[FLG_NEXT]) begin
                if (total == LIMIT) begin
                  loop_q <= 1'b1;
                  st_q   <= S_DONE;
                end else begin
                  cur_q <= mem_rsp_data_i[63:48];
                  ph_q  <= PH_DLO;
                  st_q  <= S_REQ;
                end
              end else begin
                st_q <= S_DONE;
              end
            end
          endcase
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o          = st_q != S_IDLE;
  assign mem_req_valid_o = st_q == S_REQ;
  assign seg_valid_o     = seg_v_q;
  assign seg_addr_o      = seg_addr_q;
  assign seg_len_o       = seg_len_q;
  assign seg_in_o        = seg_in_q;
  assign done_o          = st_q == S_DONE;
  assign done_empty_o    = empty_q;
  assign done_id_o       = head_q;
  assign loop_err_o      = loop_q;
endmodule

// File: rtl/vqw_checker.sv
module vqw_checker #(
  parameter int AW = 64,
  parameter int MAX_SEGS = 1024,
  parameter int CW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          mem_req_valid_o,
  input logic [AW-1:0] mem_req_addr_o,
  input logic          mem_req_ready_i,
  input logic          seg_valid_o,
  input logic          done_o,
  input logic          done_empty_o,
  input logic [CW-1:0] done_in_cnt_o,
  input logic [CW-1:0] done_out_cnt_o,
  input logic          loop_err_o
);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
  // R8
  loop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_err_o |=> loop_err_o);
  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(done_in_cnt_o) + int'(done_out_cnt_o)) <= MAX_SEGS);
  // R1
  empty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && done_empty_o |-> done_in_cnt_o == '0 && done_out_cnt_o == '0);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_valid_o && !done_o);
  // R4
  seg_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o |-> busy_o);
endmodule

bind vq_chain_walker vqw_checker #(.AW(AW), .MAX_SEGS(MAX_SEGS), .CW(CW)) i_vqw_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .mem_req_valid_o(mem_req_valid_o),
  .mem_req_addr_o(mem_req_addr_o), .mem_req_ready_i(mem_req_ready_i),
  .seg_valid_o(seg_valid_o), .done_o(done_o), .done_empty_o(done_empty_o),
  .done_in_cnt_o(done_in_cnt_o), .done_out_cnt_o(done_out_cnt_o), .loop_err_o(loop_err_o)
);

// File: tb/test_vq_chain_walker.sv
module test_vq_chain_walker;
  localparam int AW = 64;
  localparam int MS = 8;
  localparam int CW = $clog2(MS + 1);
  localparam logic [63:0] DB = 64'h1000;
  localparam logic [63:0] AB = 64'h2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch = 1'b0, skip = 1'b0, remove = 1'b0;
  logic busy, req_v, req_rdy, rsp_v, seg_v, seg_in, done, done_empty, loop_err;
  logic [63:0] req_a, rsp_d, seg_a;
  logic [31:0] seg_l;
  logic [15:0] done_id;
  logic [CW-1:0] in_cnt, out_cnt;

  always #2.5 clk = ~clk;

  vq_chain_walker #(.AW(AW), .MAX_SEGS(MS)) i_vq_chain_walker (
    .clk_i(clk), .rst_ni(rst_n), .desc_base_i(DB), .avail_base_i(AB), .qsize_i(16'd8),
    .fetch_i(fetch), .skip_i(skip), .remove_i(remove), .busy_o(busy),
    .mem_req_valid_o(req_v), .mem_req_addr_o(req_a), .mem_req_ready_i(req_rdy),
    .mem_rsp_valid_i(rsp_v), .mem_rsp_data_i(rsp_d),
    .seg_valid_o(seg_v), .seg_addr_o(seg_a), .seg_len_o(seg_l), .seg_in_o(seg_in),
    .done_o(done), .done_empty_o(done_empty), .done_id_o(done_id),
    .done_in_cnt_o(in_cnt), .done_out_cnt_o(out_cnt), .loop_err_o(loop_err)
  );

  int n_chk = 0, n_bad = 0, n_done = 0;
  logic [63:0] mem [logic [63:0]];

  function automatic logic [63:0] rd(input logic [63:0] w);
    return mem.exists(w) ? mem[w] : 64'd0;
  endfunction

  task automatic set16(input logic [63:0] a, input logic [15:0] v);
    logic [63:0] w;
    w = rd(a >> 3);
    w[a[2:1]*16 +: 16] = v;
    mem[a >> 3] = w;
  endtask

  task automatic set_desc(input int n, input logic [63:0] a, input logic [31:0] l,
                          input logic [15:0] fl, input logic [15:0] nx);
    mem[(DB + 64'(n) * 16) >> 3]     = a;
    mem[(DB + 64'(n) * 16 + 8) >> 3] = {nx, fl, l};
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory responder, one cycle latency, ready stalls every third cycle
  int cyc = 0;
  logic pend = 1'b0;
  logic [63:0] paddr = '0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_rdy <= 1'b0; rsp_v <= 1'b0; rsp_d <= '0; pend <= 1'b0; cyc <= 0;
    end else begin
      cyc <= cyc + 1;
      req_rdy <= (cyc % 3) != 0;
      rsp_v <= 1'b0;
      if (pend) begin
        rsp_v <= 1'b1; rsp_d <= rd(paddr >> 3); pend <= 1'b0;
      end
      if (req_v && req_rdy) begin
        // R9 one outstanding read
        check("R9", {62'd0, pend, rsp_v}, 64'd0);
        pend <= 1'b1; paddr <= req_a;
      end
    end
  end

  // scoreboard
  logic [63:0] q_sa[$];
  logic [31:0] q_sl[$];
  logic        q_si[$];
  logic        q_de[$], q_dc[$];
  logic [15:0] q_did[$];
  int          q_din[$], q_dout[$];
  string       q_tag[$];

  task automatic exp_seg(input logic [63:0] a, input logic [31:0] l, input logic i);
    q_sa.push_back(a); q_sl.push_back(l); q_si.push_back(i);
  endtask

  task automatic exp_done(input string tag, input logic e, input logic chk_id,
                          input logic [15:0] id, input int ni, input int no);
    q_tag.push_back(tag); q_de.push_back(e); q_dc.push_back(chk_id);
    q_did.push_back(id); q_din.push_back(ni); q_dout.push_back(no);
  endtask

  always @(negedge clk) begin
    if (rst_n && seg_v) begin
      if (q_sa.size() == 0) check("R4 unexpected segment", 64'd1, 64'd0);
      else begin
        check("R4 seg addr", seg_a, q_sa.pop_front());
        check("R4 seg len", 64'(seg_l), 64'(q_sl.pop_front()));
        check("R4 seg in tag", 64'(seg_in), 64'(q_si.pop_front()));
      end
    end
    if (rst_n && done) begin
      n_done++;
      if (q_tag.size() == 0) check("R1 unexpected done", 64'd1, 64'd0);
      else begin
        string t;
        logic c;
        logic [15:0] id;
        t = q_tag.pop_front();
        c = q_dc.pop_front();
        id = q_did.pop_front();
        check({t, " empty"}, 64'(done_empty), 64'(q_de.pop_front()));
        if (c) check({t, " id"}, 64'(done_id), 64'(id));
        check({t, " in count"}, 64'(in_cnt), 64'(q_din.pop_front()));
        check({t, " out count"}, 64'(out_cnt), 64'(q_dout.pop_front()));
        check({t, " pending segments"}, 64'(q_sa.size()), 64'd0);
      end
    end
  end

  task automatic cmd(input logic f, input logic s, input logic r);
    int d0;
    d0 = n_done;
    @(negedge clk); fetch = f; skip = s; remove = r;
    @(negedge clk); fetch = 1'b0; skip = 1'b0;
    wait (n_done == d0 + 1);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", 64'(busy), 64'd0);
    check("R10 req", 64'(req_v), 64'd0);
    check("R10 loop", 64'(loop_err), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 idle after release", {62'd0, busy, req_v}, 64'd0);

    // R1 empty queue
    exp_done("R1 empty", 1, 0, 0, 0, 0);
    cmd(1, 0, 1);

    // R2 R3 single descriptor, remove=0 keeps index (R6)
    set16(AB + 4, 16'd3);
    set_desc(3, 64'hA000, 32'd64, 16'h0, 16'h0);
    set16(AB + 2, 16'd1);
    exp_seg(64'hA000, 64, 0); exp_done("R2 head", 0, 1, 3, 0, 1);
    cmd(1, 0, 0);
    exp_seg(64'hA000, 64, 0); exp_done("R6 no remove", 0, 1, 3, 0, 1);
    cmd(1, 0, 1);
    exp_done("R6 advanced", 1, 0, 0, 0, 0);
    cmd(1, 0, 1);

    // R5 chain of three, mixed tags
    set16(AB + 6, 16'd5);
    set_desc(5, 64'hB000, 32'd100, 16'h3, 16'd2);
    set_desc(2, 64'hB100, 32'd200, 16'h1, 16'd7);
    set_desc(7, 64'hB200, 32'd300, 16'h2, 16'd0);
    set16(AB + 2, 16'd2);
    exp_seg(64'hB000, 100, 1); exp_seg(64'hB100, 200, 0); exp_seg(64'hB200, 300, 1);
    exp_done("R5 chain", 0, 1, 5, 2, 1);
    cmd(1, 0, 1);

    // R7 skip empty, then skip non-empty
    exp_done("R7 skip empty", 1, 0, 0, 0, 0);
    cmd(0, 1, 0);
    set16(AB + 8, 16'd1);
    set16(AB + 10, 16'd4);
    set_desc(4, 64'hC000, 32'd16, 16'h2, 16'd0);
    set16(AB + 2, 16'd4);
    exp_done("R7 skip", 0, 0, 0, 0, 0);
    cmd(0, 1, 0);
    exp_seg(64'hC000, 16, 1); exp_done("R7 after skip", 0, 1, 4, 1, 0);
    cmd(1, 0, 1);

    // R3 head number above queue size is masked for the table, reported raw
    set16(AB + 12, 16'd13);
    set16(AB + 2, 16'd5);
    exp_seg(64'hB000, 100, 1); exp_seg(64'hB100, 200, 0); exp_seg(64'hB200, 300, 1);
    exp_done("R3 masked", 0, 1, 13, 2, 1);
    cmd(1, 0, 1);

    // R8 chain of exactly MAX_SEGS descriptors
    for (int i = 0; i < 8; i++)
      set_desc(i, 64'hD000 + 64'(i) * 64'h100, 32'(10 + i), (i == 7) ? 16'h0 : 16'h1, 16'(i + 1));
    set16(AB + 14, 16'd0);
    set16(AB + 2, 16'd6);
    for (int i = 0; i < 8; i++) exp_seg(64'hD000 + 64'(i) * 64'h100, 32'(10 + i), 0);
    exp_done("R8 exact", 0, 1, 0, 0, 8);
    cmd(1, 0, 1);
    check("R8 no loop flag", 64'(loop_err), 64'd0);

    // R11 fetch beats skip; skip while busy ignored
    set16(AB + 16, 16'd4);
    set16(AB + 2, 16'd7);
    for (int i = 4; i < 8; i++) exp_seg(64'hD000 + 64'(i) * 64'h100, 32'(10 + i), 0);
    exp_done("R11 priority", 0, 1, 4, 0, 4);
    begin
      int d0;
      d0 = n_done;
      @(negedge clk); fetch = 1'b1; skip = 1'b1; remove = 1'b1;
      @(negedge clk); fetch = 1'b0; skip = 1'b0;
      repeat (2) @(negedge clk); skip = 1'b1;
      @(negedge clk); skip = 1'b0;
      wait (n_done == d0 + 1);
      @(negedge clk);
    end
    // consumer index is now 7; entry 7 points at a self loop
    set_desc(6, 64'hE000, 32'd8, 16'h1, 16'd6);
    set16(AB + 18, 16'd6);
    set16(AB + 2, 16'd8);
    for (int i = 0; i < 8; i++) exp_seg(64'hE000, 8, 0);
    exp_done("R8 loop", 0, 1, 6, 0, 8);
    cmd(1, 0, 1);
    check("R8 loop flag", 64'(loop_err), 64'd1);
    exp_done("R8 sticky empty", 1, 0, 0, 0, 0);
    cmd(1, 0, 1);
    check("R8 loop sticky", 64'(loop_err), 64'd1);
    check("R4 leftover segments", 64'(q_sa.size()), 64'd0);
    check("R1 leftover completions", 64'(q_tag.size()), 64'd0);
    summary();
  end
endmodule